// File: doc/BRIEF.md
# Double-Buffered Serial DAC Code Front End

This block is the digital front end of a 12-bit serial-input converter. A serial word enters a shift register one bit per rising serial-clock edge while the active-low select is held low, most significant bit first. The code presented to the converter core comes from a separate holding register. New data can therefore be preloaded without disturbing the code currently on the output.

The active-low load strobe is level-sensitive. For as long as it is held low, the holding register follows the shift register on every system clock. The active-low clear is asynchronous and forces the holding register to zero at any moment. It overrides the load strobe and leaves the shift register untouched.

Shifting a bit while the load strobe is still low breaks the protocol. That event sets a sticky error flag, which only the synchronous reset clears. All serial and strobe inputs are taken to be synchronous to the system clock. A serial-clock rising edge is recognised by comparing the input with its value at the previous system clock.

Top module: `dacif_top`

## Requirements
- R1: While `rst` is high, `dacCode` and `protoErr` are both zero at the next clock edge and remain zero until `rst` falls.
- R2: Each rising edge of `serClk` seen while `csN` is low shifts `serData` into bit 0 of the shift register, with earlier bits moving toward bit 11. Twelve edges followed by a load therefore place the first bit sent at `dacCode[11]`.
- R3: Rising edges of `serClk` while `csN` is high leave the shift register unchanged. A later load shows the previous word.
- R4: While `ldN` is high and `clrN` is high, `dacCode` does not change, including while a word is being shifted in.
- R5: While `ldN` is low and `clrN` is high, `dacCode` equals the shift register contents after each clock edge. A load pulse of one clock cycle is enough to update the output.
- R6: When `clrN` goes low, `dacCode` becomes zero without waiting for a clock edge. It stays zero while `clrN` is low, whatever the level of `ldN`.
- R7: Clear does not alter the shift register. A load after clear is released presents the word shifted in before the clear.
- R8: A `serClk` rising edge with `csN` low and `ldN` low sets `protoErr` high at that clock edge. The flag then stays high, whatever the other inputs do, until `rst`.
- R9: `serClk` edges with `csN` high while `ldN` is low do not set `protoErr` and do not change `dacCode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| serClk | input | 1 | Serial bit clock, sampled by `clk` |
| serData | input | 1 | Serial data bit, MSB first |
| csN | input | 1 | Active-low select gating the serial clock |
| ldN | input | 1 | Active-low level-sensitive transfer strobe |
| clrN | input | 1 | Active-low asynchronous clear of the output code |
| dacCode | output | 12 | Code driven to the converter core |
| protoErr | output | 1 | Sticky flag: bit shifted while load was low |

## Verification
Load and clear can act in the same cycle, and so can load and a shift. The bench holds `ldN` low across the fall and rise of `clrN`. The code must read zero immediately after the clear falls and must stay zero through several clock edges. It must then return to the stored word on the first edge after the clear is released. For the load-and-shift overlap, the bench sends a serial edge while the strobe is low. It first does so with select high, where no flag and no code change are expected. It then does so with select low, where the sticky flag is expected to rise and to survive the end of the load pulse.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int CODE_W = 12;

  typedef struct packed {
    logic shiftEn;
    logic loadEn;
  } dacifStrobes_t;
endpackage

// File: rtl/dacif_ctrl.sv
module dacif_ctrl
  import dacif_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          serClk,
  input  logic          csN,
  input  logic          ldN,
  output dacifStrobes_t strobes,
  output logic          protoErr
);
  logic serClkQ;
  logic serRise;
  logic errQ;

  always_ff @(posedge clk) begin
    if (rst) serClkQ <= 1'b0;
    else     serClkQ <= serClk;
  end

  assign serRise = serClk & ~serClkQ;

  always_comb begin
    strobes.shiftEn = serRise & ~csN;
    strobes.loadEn  = ~ldN;
  end

  always_ff @(posedge clk) begin
    if (rst)                                    errQ <= 1'b0;
    else if (strobes.shiftEn && strobes.loadEn) errQ <= 1'b1;
  end

  assign protoErr = errQ;
endmodule

// File: rtl/dacif_datapath.sv
module dacif_datapath
  import dacif_pkg::*;
#(
  parameter int WIDTH = CODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clrN,
  input  logic             serData,
  input  dacifStrobes_t    strobes,
  output logic [WIDTH-1:0] code
);
  localparam int MSB = WIDTH - 1;

  logic [MSB:0] shiftReg;
  logic [MSB:0] holdReg;

  always_ff @(posedge clk) begin
    if (rst)                  shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= {shiftReg[MSB-1:0], serData};
  end

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN)               holdReg <= '0;
    else if (rst)            holdReg <= '0;
    else if (strobes.loadEn) holdReg <= shiftReg;
  end

  assign code = holdReg;
endmodule

// File: rtl/dacif_top.sv
module dacif_top
  import dacif_pkg::*;
#(
  parameter int WIDTH = CODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             serClk,
  input  logic             serData,
  input  logic             csN,
  input  logic             ldN,
  input  logic             clrN,
  output logic [WIDTH-1:0] dacCode,
  output logic             protoErr
);
  dacifStrobes_t strobes;

  dacif_ctrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .serClk  (serClk),
    .csN     (csN),
    .ldN     (ldN),
    .strobes (strobes),
    .protoErr(protoErr)
  );

  dacif_datapath #(.WIDTH(WIDTH)) uPath (
    .clk    (clk),
    .rst    (rst),
    .clrN   (clrN),
    .serData(serData),
    .strobes(strobes),
    .code   (dacCode)
  );
endmodule

// File: rtl/dacif_checker.sv
module dacif_checker #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             serClk,
  input logic             csN,
  input logic             ldN,
  input logic             clrN,
  input logic [WIDTH-1:0] dacCode,
  input logic             protoErr
);
  logic armed;
  logic sclkSeen;
  logic badEdge;
  logic quietEdge;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      sclkSeen <= 1'b0;
    end else begin
      armed    <= 1'b1;
      sclkSeen <= serClk;
    end
  end

  assign badEdge   = serClk & ~sclkSeen & ~csN & ~ldN;
  assign quietEdge = serClk & ~sclkSeen & csN & ~ldN;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (dacCode == '0 && !protoErr));

  assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (armed && ldN && clrN) |=> (!clrN || $stable(dacCode)));

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !clrN |-> (dacCode == '0));

  assert_err_raised_R8: assert property (@(posedge clk) disable iff (rst)
    (armed && badEdge) |=> protoErr);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (armed && protoErr) |=> protoErr);

  assert_no_err_deselected_R9: assert property (@(posedge clk) disable iff (rst)
    (armed && quietEdge && !protoErr) |=> !protoErr);
endmodule

bind dacif_top dacif_checker #(.WIDTH(WIDTH)) uChecker (
  .clk     (clk),
  .rst     (rst),
  .serClk  (serClk),
  .csN     (csN),
  .ldN     (ldN),
  .clrN    (clrN),
  .dacCode (dacCode),
  .protoErr(protoErr)
);

// File: tb/dacif_top_test.sv
`timescale 1ns/1ps
module dacif_top_test;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         serClk = 1'b0;
  logic         serData = 1'b0;
  logic         csN = 1'b1;
  logic         ldN = 1'b1;
  logic         clrN = 1'b1;
  logic [W-1:0] dacCode;
  logic         protoErr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dacif_top #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .serClk(serClk), .serData(serData),
    .csN(csN), .ldN(ldN), .clrN(clrN), .dacCode(dacCode), .protoErr(protoErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  // shift a word MSB first; verify output holds when ldN is high (R4)
  task automatic shiftWord(input logic [W-1:0] word, input logic [W-1:0] holdExp);
    @(negedge clk);
    csN = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      @(negedge clk);
      serData = word[i];
      serClk  = 1'b0;
      @(negedge clk);
      serClk = 1'b1;
      @(negedge clk);
      @(negedge clk);
      if (ldN) check(dacCode == holdExp, "R4 hold during shift", dacCode, holdExp);
    end
    @(negedge clk);
    serClk = 1'b0;
    csN = 1'b1;
  endtask

  task automatic pulseLoad(input logic [W-1:0] exp, input string req);
    @(negedge clk);
    ldN = 1'b0;
    settle();
    check(dacCode == exp, req, dacCode, exp);
    @(negedge clk);
    ldN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(dacCode == '0, "R1 code after reset", dacCode, 0);
    check(protoErr == 1'b0, "R1 flag after reset", protoErr, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic testShiftLoad();
    shiftWord(12'hA5C, 12'h000);
    pulseLoad(12'hA5C, "R2 R5 load A5C");
    shiftWord(12'h3F1, 12'hA5C);
    check(dacCode == 12'hA5C, "R4 output before load", dacCode, 12'hA5C);
    pulseLoad(12'h3F1, "R2 R5 load 3F1");
    shiftWord(12'h800, 12'h3F1);
    pulseLoad(12'h800, "R2 MSB only");
    shiftWord(12'h001, 12'h800);
    pulseLoad(12'h001, "R2 LSB only");
    shiftWord(12'hFFF, 12'h001);
    pulseLoad(12'hFFF, "R2 all ones");
  endtask

  task automatic testDeselect();
    shiftWord(12'h3F1, 12'hFFF);
    pulseLoad(12'h3F1, "R2 reload 3F1");
    @(negedge clk);
    csN = 1'b1;
    serData = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); serClk = 1'b1;
      @(negedge clk); serClk = 1'b0;
    end
    pulseLoad(12'h3F1, "R3 deselected edges ignored");
  endtask

  task automatic testClear();
    @(negedge clk);
    clrN = 1'b0;
    #1;
    check(dacCode == '0, "R6 immediate clear", dacCode, 0);
    @(negedge clk);
    ldN = 1'b0;
    repeat (3) @(negedge clk);
    check(dacCode == '0, "R6 clear beats load", dacCode, 0);
    clrN = 1'b1;
    settle();
    check(dacCode == 12'h3F1, "R7 word kept through clear", dacCode, 12'h3F1);
    @(negedge clk);
    ldN = 1'b1;
    @(negedge clk);
    clrN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    clrN = 1'b1;
    @(negedge clk);
    check(dacCode == '0, "R4 stays cleared with ldN high", dacCode, 0);
    pulseLoad(12'h3F1, "R7 reload after clear");
  endtask

  task automatic testViolation();
    @(negedge clk);
    ldN = 1'b0;
    csN = 1'b1;
    serData = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); serClk = 1'b1;
      @(negedge clk); serClk = 1'b0;
    end
    @(negedge clk);
    check(protoErr == 1'b0, "R9 no flag when deselected", protoErr, 0);
    check(dacCode == 12'h3F1, "R9 code unchanged", dacCode, 12'h3F1);
    csN = 1'b0;
    serClk = 1'b1;
    settle();
    check(protoErr == 1'b1, "R8 flag on shift during load", protoErr, 1);
    @(negedge clk);
    serClk = 1'b0;
    csN = 1'b1;
    ldN = 1'b1;
    repeat (5) @(negedge clk);
    check(protoErr == 1'b1, "R8 flag sticky", protoErr, 1);
    rst = 1'b1;
    settle();
    check(protoErr == 1'b0, "R8 flag cleared by reset", protoErr, 0);
    check(dacCode == '0, "R1 code cleared by reset", dacCode, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    testReset();
    testShiftLoad();
    testDeselect();
    testClear();
    testViolation();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule